// File: doc/BRIEF.md
# Pipelined Wishbone Block RAM Slave

This block is an on-chip word memory reached through a pipelined Wishbone B4 slave port. A master can present one request per clock. A request is a read or a byte-masked write of one data word at a word address. Each accepted request is answered by exactly one ack, and acks come back in request order. A read ack carries the addressed word on the data output.

The word count is a parameter and need not be a power of two; the address width is derived from it. A latency parameter adds pipeline cycles between acceptance and ack. An optional output register adds one more cycle, so that the RAM read is kept off the critical path. Writes land in the array in the cycle they are accepted. When no older ack is still travelling, a write is acknowledged on the next cycle and so overtakes the read pipeline. With the latency parameter at zero the slave raises stall for as long as a request is outstanding. A classic master that holds strobe until it sees ack therefore gets exactly one response.

Top module: `pipe_wb_ram`

## Requirements
- R1: The address input is ceil(log2(WORDS)) bits wide and selects one word. A write to an index at or above WORDS changes no word, and a read of such an index returns all zeros.
- R2: A read accepted in cycle c is acknowledged in cycle c+1+LATENCY+OUT_REG, with the stored word on the data output in that same cycle.
- R3: On a write, sel bit i enables data bits [8i+7:8i] of the addressed word. Lanes whose sel bit is 0 keep their old contents, and a write with sel all zero leaves the word unchanged.
- R4: A write accepted while no older request is waiting for its ack is acknowledged in the following cycle, whatever the configured latency.
- R5: Each accepted request receives exactly one ack, and acks arrive in the order the requests were accepted. A write accepted behind a pending ack takes the normal slot of 1+LATENCY+OUT_REG cycles.
- R6: With LATENCY above zero, stall stays low and a new request can be accepted in every cycle.
- R7: With LATENCY equal to zero, stall is high from the cycle after a request is accepted up to and including its ack cycle. A master that holds strobe until ack receives a single ack.
- R8: While cyc is low, ack is low and every pending ack is discarded; none appears after cyc returns. A write that was accepted before cyc fell stays in the memory.
- R9: While reset is asserted and right after its release, ack and stall are low and no ack is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| wb_cyc_i | input | 1 | Bus cycle active; low discards pending acks |
| wb_stb_i | input | 1 | Request strobe |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ceil(log2(WORDS)) | Word address |
| wb_sel_i | input | DATA_W/8 | Byte-lane write enables |
| wb_dat_i | input | DATA_W | Write data |
| wb_dat_o | output | DATA_W | Read data, valid with a read ack |
| wb_ack_o | output | 1 | Request acknowledge |
| wb_stall_o | output | 1 | Request cannot be accepted this cycle |

## Verification
The bench targets the ordering between fast write acks and slow read acks. A design that always acked writes early would return a write ack ahead of an older read, or give two acks in one slot. A design that never acked early would show the full latency on an isolated write. Dropping cyc with a read in flight, and with an early write ack due, exposes a design that lets a stale ack leak out after the cycle ends. The same test catches a design that also discards the write. A zero-latency instance driven by a master that holds strobe until ack catches a missing stall as a duplicate ack. Masked writes and the addresses just past the last word catch lane mix-ups and aliasing of out-of-range indices onto real words.

// File: rtl/pwr_pkg.sv
`timescale 1ns/1ps
package pwr_pkg;

  typedef enum logic {
    PWR_CLASSIC = 1'b0,
    PWR_PIPED   = 1'b1
  } pwr_mode_e;

  // number of ack-tracking stages between acceptance and ack
  function automatic int unsigned pwr_depth(input int unsigned lat, input int unsigned oreg);
    return 1 + lat + ((oreg != 0) ? 1 : 0);
  endfunction

  function automatic pwr_mode_e pwr_mode(input int unsigned lat);
    return (lat == 0) ? PWR_CLASSIC : PWR_PIPED;
  endfunction

endpackage

// File: rtl/pwr_rst_sync.sv
`timescale 1ns/1ps
module pwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_n;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_n;
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_mem.sv
`timescale 1ns/1ps
module pwr_mem #(
  parameter int unsigned WORDS  = 24,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = DATA_W / 8,
  parameter int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdat,
  output logic [DATA_W-1:0] rd_q
);

  localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(WORDS);

  logic [DATA_W-1:0] mem [WORDS];
  logic              in_range;
  logic              wr_go;
  logic [DATA_W-1:0] rd_n;

  assign in_range = ({1'b0, addr} < LIMIT);
  assign wr_go    = wr_en & in_range;

  // storage array: byte lanes gated by sel, no reset on the array
  always_ff @(posedge clk) begin
    if (wr_go) begin
      for (int b = 0; b < int'(SEL_W); b++) begin
        if (sel[b]) mem[addr][8*b +: 8] <= wdat[8*b +: 8];
      end
    end
  end

  // first read stage: captured word, or zero beyond the last word
  always_comb begin
    rd_n = rd_q;
    if (rd_en) rd_n = in_range ? mem[addr] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_n;
  end

  // a full-word write followed by a read of the same index returns that word
  assert_wr_then_rd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && in_range && (&sel)) ##1 (rd_en && addr == $past(addr))
      |=> rd_q == $past(wdat, 2));

endmodule

// File: rtl/pwr_track.sv
`timescale 1ns/1ps
module pwr_track #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_i,
  input  logic              rd_acc,
  input  logic              wr_acc,
  input  logic [DATA_W-1:0] rd_q,
  output logic              ack_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              busy_o
);

  // stages older than the final one; empty means no older ack in flight
  localparam logic [DEPTH-1:0] OLDER_MASK = {DEPTH{1'b1}} >> 1;

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_n;
  logic             older_empty;
  logic             shift_en;

  assign older_empty = ((vld_q & OLDER_MASK) == '0);
  assign shift_en    = |vld_q;

  always_comb begin
    vld_n = '0;
    if (cyc_i) begin
      vld_n    = vld_q << 1;
      vld_n[0] = rd_acc | (wr_acc & ~older_empty);
      if (wr_acc & older_empty) vld_n[DEPTH-1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  generate
    if (DEPTH > 1) begin : g_dpipe
      logic [DATA_W-1:0] dq [DEPTH-1];
      always_ff @(posedge clk) begin
        if (shift_en) begin
          dq[0] <= rd_q;
          for (int i = 1; i < int'(DEPTH) - 1; i++) dq[i] <= dq[i-1];
        end
      end
      assign dat_o = dq[DEPTH-2];
    end else begin : g_direct
      assign dat_o = rd_q;
    end
  endgenerate

  assign ack_o  = vld_q[DEPTH-1] & cyc_i;
  assign busy_o = |vld_q;

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_i |=> !ack_o);

  assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && older_empty) |=> (ack_o || !cyc_i));

  assert_late_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !older_empty && cyc_i) |=> busy_o);

endmodule

// File: rtl/pipe_wb_ram.sv
`timescale 1ns/1ps
module pipe_wb_ram #(
  parameter int unsigned WORDS   = 24,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LATENCY = 2,
  parameter int unsigned OUT_REG = 1,
  localparam int unsigned SEL_W  = DATA_W / 8,
  localparam int unsigned ADDR_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [SEL_W-1:0]  wb_sel_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  output logic              wb_stall_o
);
  import pwr_pkg::*;

  localparam int unsigned DEPTH   = pwr_depth(LATENCY, OUT_REG);
  localparam pwr_mode_e   MODE    = pwr_mode(LATENCY);
  localparam logic        CLASSIC = (MODE == PWR_CLASSIC);

  logic rst_n;
  logic busy;
  logic acc;
  logic rd_acc;
  logic wr_acc;
  logic [DATA_W-1:0] rd_q;

  pwr_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  // classic mode holds off new work until the outstanding ack is out
  assign wb_stall_o = CLASSIC & busy;
  assign acc        = wb_cyc_i & wb_stb_i & ~wb_stall_o;
  assign rd_acc     = acc & ~wb_we_i;
  assign wr_acc     = acc &  wb_we_i;

  pwr_mem #(
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W),
    .ADDR_W (ADDR_W)
  ) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_acc),
    .rd_en (rd_acc),
    .addr  (wb_adr_i),
    .sel   (wb_sel_i),
    .wdat  (wb_dat_i),
    .rd_q  (rd_q)
  );

  pwr_track #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .cyc_i  (wb_cyc_i),
    .rd_acc (rd_acc),
    .wr_acc (wr_acc),
    .rd_q   (rd_q),
    .ack_o  (wb_ack_o),
    .dat_o  (wb_dat_o),
    .busy_o (busy)
  );

  assert_classic_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (CLASSIC && acc) |=> wb_stall_o);

  assert_classic_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (CLASSIC && wb_ack_o) |-> wb_stall_o);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (!wb_ack_o && !wb_stall_o));

endmodule

// File: tb/pipe_wb_ram_tb.sv
`timescale 1ns/1ps
module pipe_wb_ram_tb;

  typedef struct packed {
    logic        we;
    logic [4:0]  adr;
    logic [3:0]  sel;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  lat;
  } vec_t;

  localparam int NV = 15;
  // default instance: 24 words, read ack 4 cycles after acceptance
  localparam vec_t VEC [NV] = '{
    '{1'b1, 5'd3,  4'hF, 32'h11223344, 32'h0,        4'd1}, // R4 isolated write
    '{1'b1, 5'd3,  4'h5, 32'hAABBCCDD, 32'h0,        4'd1}, // R3 lanes 0 and 2
    '{1'b0, 5'd3,  4'h0, 32'h0,        32'h11BB33DD, 4'd4}, // R2 R3
    '{1'b1, 5'd3,  4'h0, 32'hFFFFFFFF, 32'h0,        4'd1}, // R3 no lanes
    '{1'b0, 5'd3,  4'h0, 32'h0,        32'h11BB33DD, 4'd4}, // R3 unchanged
    '{1'b1, 5'd23, 4'hF, 32'hCAFEF00D, 32'h0,        4'd1}, // R1 last word
    '{1'b0, 5'd23, 4'h0, 32'h0,        32'hCAFEF00D, 4'd4},
    '{1'b1, 5'd24, 4'hF, 32'hDEADBEEF, 32'h0,        4'd1}, // R1 first beyond
    '{1'b0, 5'd24, 4'h0, 32'h0,        32'h00000000, 4'd4},
    '{1'b0, 5'd23, 4'h0, 32'h0,        32'hCAFEF00D, 4'd4}, // R1 no alias
    '{1'b1, 5'd0,  4'hF, 32'h00000000, 32'h0,        4'd1},
    '{1'b1, 5'd0,  4'hA, 32'h12345678, 32'h0,        4'd1}, // R3 lanes 1 and 3
    '{1'b0, 5'd0,  4'h0, 32'h0,        32'h12005600, 4'd4},
    '{1'b1, 5'd31, 4'hF, 32'h5555AAAA, 32'h0,        4'd1}, // R1 top index
    '{1'b0, 5'd31, 4'h0, 32'h0,        32'h00000000, 4'd4}
  };

  logic        clk;
  logic        arst_n;
  logic        cyc, stb, we;
  logic [4:0]  adr;
  logic [3:0]  sel;
  logic [31:0] wdat, rdat;
  logic        ack, stall;
  logic        c_cyc, c_stb, c_we;
  logic [4:0]  c_adr;
  logic [3:0]  c_sel;
  logic [31:0] c_wdat, c_rdat;
  logic        c_ack, c_stall;
  int          checks;
  int          fails;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  pipe_wb_ram u_dut (
    .clk(clk), .arst_n(arst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_sel_i(sel), .wb_dat_i(wdat), .wb_dat_o(rdat),
    .wb_ack_o(ack), .wb_stall_o(stall)
  );

  pipe_wb_ram #(.WORDS(24), .DATA_W(32), .LATENCY(0), .OUT_REG(1)) u_cls (
    .clk(clk), .arst_n(arst_n), .wb_cyc_i(c_cyc), .wb_stb_i(c_stb), .wb_we_i(c_we),
    .wb_adr_i(c_adr), .wb_sel_i(c_sel), .wb_dat_i(c_wdat), .wb_dat_o(c_rdat),
    .wb_ack_o(c_ack), .wb_stall_o(c_stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic c, input logic s, input logic w, input logic [4:0] a,
                     input logic [3:0] m, input logic [31:0] d);
    cyc = c; stb = s; we = w; adr = a; sel = m; wdat = d;
  endtask

  // one request, then watch 8 cycles for its ack(s)
  task automatic do_op(input logic w, input logic [4:0] a, input logic [3:0] m,
                       input logic [31:0] d, output int lat, output logic [31:0] data,
                       output int n);
    lat = 0; data = '0; n = 0;
    @(negedge clk);
    put(1'b1, 1'b1, w, a, m, d);
    for (int s = 1; s <= 8; s++) begin
      @(negedge clk);
      if (ack) begin
        n++;
        if (lat == 0) begin lat = s; data = rdat; end
      end
      stb = 1'b0;
    end
    cyc = 1'b0;
  endtask

  // classic-mode master: hold strobe until ack is seen
  task automatic cls_op(input logic w, input logic [4:0] a, input logic [31:0] d,
                        input int exp_lat, input logic [31:0] exp_d);
    int n;
    int at;
    logic [31:0] got;
    n = 0; at = 0; got = '0;
    @(negedge clk);
    c_cyc = 1'b1; c_stb = 1'b1; c_we = w; c_adr = a; c_sel = 4'hF; c_wdat = d;
    for (int s = 1; s <= 6; s++) begin
      @(negedge clk);
      if (at == 0) chk("R7 stall high while outstanding", 32'(c_stall), 32'd1);
      if (c_ack) begin
        n++;
        if (at == 0) begin at = s; got = c_rdat; end
        c_stb = 1'b0;
      end
    end
    c_cyc = 1'b0;
    chk("R7 single ack for held strobe", 32'(n), 32'd1);
    chk("R7 classic ack cycle", 32'(at), 32'(exp_lat));
    if (!w) chk("R7 classic read data", got, exp_d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    int n;
    logic [31:0] data;
    checks = 0; fails = 0;
    arst_n = 1'b0;
    put(1'b0, 1'b0, 1'b0, 5'd0, 4'h0, 32'h0);
    c_cyc = 1'b0; c_stb = 1'b0; c_we = 1'b0; c_adr = '0; c_sel = '0; c_wdat = '0;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 ack in reset", 32'(ack), 32'd0);
    chk("R9 stall in reset", 32'(stall), 32'd0);
    chk("R9 classic stall in reset", 32'(c_stall), 32'd0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 ack after release", 32'(ack), 32'd0);
    chk("R9 classic ack after release", 32'(c_ack), 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      do_op(VEC[i].we, VEC[i].adr, VEC[i].sel, VEC[i].wd, lat, data, n);
      chk(VEC[i].we ? "R4 write ack cycle" : "R2 read ack cycle", 32'(lat), 32'(VEC[i].lat));
      chk("R5 one ack per request", 32'(n), 32'd1);
      if (!VEC[i].we) chk("R1/R3 read data", data, VEC[i].exp);
    end

    // back-to-back reads: acks at 4,5,6 in order, never stalled
    @(negedge clk);
    put(1'b1, 1'b1, 1'b0, 5'd3, 4'h0, 32'h0);
    chk("R6 stall low under load", 32'(stall), 32'd0);
    for (int s = 1; s <= 8; s++) begin
      @(negedge clk);
      chk("R5 ordered read acks", 32'(ack), 32'((s >= 4) && (s <= 6)));
      if (s == 4) chk("R2 first pipelined data", rdat, 32'h11BB33DD);
      if (s == 5) chk("R2 second pipelined data", rdat, 32'hCAFEF00D);
      if (s == 6) chk("R2 third pipelined data", rdat, 32'h12005600);
      if (s == 1) begin adr = 5'd23; chk("R6 stall low under load", 32'(stall), 32'd0); end
      else if (s == 2) adr = 5'd0;
      else stb = 1'b0;
    end
    cyc = 1'b0;

    // read then write: write waits its turn, no early ack
    @(negedge clk);
    put(1'b1, 1'b1, 1'b0, 5'd3, 4'h0, 32'h0);
    for (int s = 1; s <= 7; s++) begin
      @(negedge clk);
      chk("R5 write queued behind read", 32'(ack), 32'((s == 4) || (s == 5)));
      if (s == 1) put(1'b1, 1'b1, 1'b1, 5'd5, 4'hF, 32'h0BADF00D);
      else stb = 1'b0;
    end
    cyc = 1'b0;
    do_op(1'b0, 5'd5, 4'h0, 32'h0, lat, data, n);
    chk("R5 queued write stored", data, 32'h0BADF00D);

    // write then read: early write ack, read sees new word
    @(negedge clk);
    put(1'b1, 1'b1, 1'b1, 5'd6, 4'hF, 32'h600DCAFE);
    for (int s = 1; s <= 7; s++) begin
      @(negedge clk);
      chk("R4 early write then read", 32'(ack), 32'((s == 1) || (s == 5)));
      if (s == 5) chk("R4 read after early write", rdat, 32'h600DCAFE);
      if (s == 1) put(1'b1, 1'b1, 1'b0, 5'd6, 4'h0, 32'h0);
      else stb = 1'b0;
    end
    cyc = 1'b0;

    // cyc drop with a read in flight
    @(negedge clk);
    put(1'b1, 1'b1, 1'b0, 5'd3, 4'h0, 32'h0);
    for (int s = 1; s <= 8; s++) begin
      @(negedge clk);
      chk("R8 pending read ack discarded", 32'(ack), 32'd0);
      if (s == 1) begin cyc = 1'b0; stb = 1'b0; end
      if (s == 3) cyc = 1'b1;
    end
    cyc = 1'b0;

    // cyc drop when an early write ack is due
    @(negedge clk);
    put(1'b1, 1'b1, 1'b1, 5'd7, 4'hF, 32'h77007700);
    @(negedge clk);
    cyc = 1'b0; stb = 1'b0;
    #1;
    chk("R8 ack masked while cyc low", 32'(ack), 32'd0);
    @(negedge clk);
    cyc = 1'b1;
    #1;
    chk("R8 no ack after cyc returns", 32'(ack), 32'd0);
    cyc = 1'b0;
    do_op(1'b0, 5'd7, 4'h0, 32'h0, lat, data, n);
    chk("R8 accepted write kept", data, 32'h77007700);

    // classic instance
    cls_op(1'b1, 5'd2, 32'h13579BDF, 1, 32'h0);
    cls_op(1'b0, 5'd2, 32'h0, 2, 32'h13579BDF);
    @(negedge clk);
    chk("R7 stall released after ack", 32'(c_stall), 32'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule